// File: doc/BRIEF.md
# Serial configuration memory command slave

This block is the device end of a four-wire serial memory link. A host drives an active-low select, a serial clock and a serial data line. The block returns data on one output line, together with a drive enable that an external tri-state buffer uses. All four link pins are brought into the block's own clock domain through a short synchronizer. Edges of the serial clock are detected there, so the serial clock must run well below the system clock.

Each low period of the select line begins with an 8-bit opcode, sent most significant bit first. Four commands are decoded: write enable, write status, read status and read bytes. The read data comes from a small internal array whose contents are computed from a seed parameter. A status register holds a write-enable latch, a busy flag and a group of protection bits. A status write that is framed correctly starts a self-timed busy period. That period is modelled by a down-counter of parameter length.

Top module: `serialCfgSlave`

## Requirements
- R1: After reset the drive enable `sdoOe` is low and the status byte reads 0x00.
- R2: Opcode 0x06 sets the write-enable latch, which is status bit 1.
- R3: Opcode 0x05 returns the status byte, most significant bit first, and repeats it for every further byte until select rises. The status byte has the busy flag in bit 0, the write-enable latch in bit 1 and the protection bits in bits [4:2]. Bits [7:5] read 0.
- R4: A status write (opcode 0x01 followed by one data byte) is ignored when the write-enable latch is clear.
- R5: An accepted status write copies data bits [4:2] into the protection bits. No other status bit takes a value from the data byte.
- R6: A status write takes effect only if select rises straight after the eighth data bit. With fewer or more data bits the write is discarded.
- R7: An accepted status write sets the busy flag for BUSY_CYCLES clock cycles. When that period ends, the busy flag and the write-enable latch both clear.
- R8: While the busy flag is set, only opcode 0x05 is decoded. All other opcodes are ignored, and a read-bytes command drives no output.
- R9: Opcode 0x03 is followed by a 24-bit address, sent most significant bit first. The data then starts on the next falling serial-clock edge, most significant bit first, one bit per falling edge. The byte at index i is (i*29 + MEM_SEED) mod 256. The index is the address modulo MEM_DEPTH, which is a power of two.
- R10: During a read the index advances after each byte and wraps from MEM_DEPTH-1 to 0, for as long as select stays low.
- R11: `sdoOe` is high only in the data phase of a read command. It rises at the first falling edge after the command bits and drops once select is high.
- R12: Raising select at any point aborts decoding. An unknown opcode is ignored until select rises, and the next low period decodes a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host, sampled on rising serial-clock edges |
| sdo | output | 1 | Serial data to the host, updated on falling serial-clock edges |
| sdoOe | output | 1 | Drive enable for the external tri-state buffer on `sdo` |

## Verification
The bench builds the block with MEM_DEPTH = 16, MEM_SEED = 0x5A and BUSY_CYCLES = 1000. The small array lets a read that starts at index 14 wrap to index 0 within three bytes. It also shows that the upper address bits are dropped. The busy period is long enough for a status read and a blocked read-bytes attempt to fall inside it, and short enough that the end of busy, with the write-enable latch clearing, is seen within a few thousand cycles.

// File: rtl/serialCfgPkg.sv
package serialCfgPkg;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_READ = 8'h03;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_READ,
    ST_RSTAT,
    ST_WDATA,
    ST_WHOLD,
    ST_SKIP
  } ctrlState_t;

  typedef struct packed {
    logic loadAddr;
    logic startRead;
    logic startStatus;
    logic shiftOut;
    logic setWel;
    logic captureData;
    logic commitStatus;
  } ctrlStrobe_t;

endpackage

// File: rtl/serialCfgSync.sv
module serialCfgSync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= {STAGES{RST_VAL}};
    else       stg <= {stg[STAGES-2:0], din};
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/serialCfgCtrl.sv
module serialCfgCtrl
  import serialCfgPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csHigh,
  input  logic        csRiseEv,
  input  logic        riseEv,
  input  logic        fallEv,
  input  logic        byteDone,
  input  logic [7:0]  rxByte,
  input  logic        wip,
  input  logic        wel,
  output ctrlStrobe_t strobe
);

  ctrlState_t state, stateNext;
  logic [1:0] addrCnt, addrCntNext;

  always_comb begin
    strobe      = '0;
    stateNext   = state;
    addrCntNext = addrCnt;
    if (csHigh) begin
      stateNext   = ST_OPC;
      addrCntNext = 2'd0;
      if (state == ST_WHOLD && csRiseEv && wel) strobe.commitStatus = 1'b1;
    end else begin
      unique case (state)
        ST_OPC: begin
          if (byteDone) begin
            if (wip && rxByte != OPC_RDSR) begin
              stateNext = ST_SKIP;
            end else begin
              unique case (rxByte)
                OPC_WREN: begin
                  strobe.setWel = 1'b1;
                  stateNext     = ST_SKIP;
                end
                OPC_WRSR: stateNext = wel ? ST_WDATA : ST_SKIP;
                OPC_RDSR: begin
                  strobe.startStatus = 1'b1;
                  stateNext          = ST_RSTAT;
                end
                OPC_READ: begin
                  addrCntNext = 2'd0;
                  stateNext   = ST_ADDR;
                end
                default: stateNext = ST_SKIP;
              endcase
            end
          end
        end
        ST_ADDR: begin
          if (byteDone) begin
            strobe.loadAddr = 1'b1;
            if (addrCnt == 2'd2) begin
              strobe.startRead = 1'b1;
              stateNext        = ST_READ;
            end else begin
              addrCntNext = addrCnt + 2'd1;
            end
          end
        end
        ST_READ, ST_RSTAT: strobe.shiftOut = fallEv;
        ST_WDATA: begin
          if (byteDone) begin
            strobe.captureData = 1'b1;
            stateNext          = ST_WHOLD;
          end
        end
        ST_WHOLD: if (riseEv) stateNext = ST_SKIP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OPC;
      addrCnt <= 2'd0;
    end else begin
      state   <= stateNext;
      addrCnt <= addrCntNext;
    end
  end

endmodule

// File: rtl/serialCfgDatapath.sv
module serialCfgDatapath
  import serialCfgPkg::*;
#(
  parameter int MEM_DEPTH = 64,
  parameter int MEM_SEED = 8'hA5,
  parameter int BP_W = 3,
  parameter int BUSY_CYCLES = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  ctrlStrobe_t       strobe,
  output logic              csHigh,
  output logic              csRiseEv,
  output logic              riseEv,
  output logic              fallEv,
  output logic              byteDone,
  output logic [7:0]        rxByte,
  output logic              wip,
  output logic              wel,
  output logic [BP_W-1:0]   bp,
  output logic              sdo,
  output logic              sdoOe
);

  localparam int ADDR_W = $clog2(MEM_DEPTH);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int BP_LSB = 2;

  function automatic logic [7:0] romByte(input logic [ADDR_W-1:0] idx);
    logic [31:0] t;
    t = 32'(idx) * 32'd29 + 32'(MEM_SEED);
    return t[7:0];
  endfunction

  logic       csS, sclkS, sdiS;
  logic       csPrev, sclkPrev;

  serialCfgSync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rstN(rstN), .din({csN, sclk, sdi}), .dout({csS, sclkS, sdiS})
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csHigh   = csS;
  assign csRiseEv = csS & ~csPrev;
  assign riseEv   = ~csS & sclkS & ~sclkPrev;
  assign fallEv   = ~csS & ~sclkS & sclkPrev;

  // receive shifter
  logic [2:0] bitCnt;
  logic [7:0] shiftIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= 3'd0;
      shiftIn <= 8'd0;
    end else if (csS) begin
      bitCnt <= 3'd0;
    end else if (riseEv) begin
      bitCnt  <= bitCnt + 3'd1;
      shiftIn <= {shiftIn[6:0], sdiS};
    end
  end

  assign rxByte   = {shiftIn[6:0], sdiS};
  assign byteDone = riseEv && (bitCnt == 3'd7);

  // address assembly
  logic [15:0]       addrAsm;
  logic [ADDR_W-1:0] startIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addrAsm <= 16'd0;
    else if (strobe.loadAddr) addrAsm <= {addrAsm[7:0], rxByte};
  end

  assign startIdx = ADDR_W'({addrAsm, rxByte});

  // status register
  logic [BUSY_W-1:0] busyCnt;
  logic [BP_W-1:0]   dataHold;
  logic              welReg;
  logic [BP_W-1:0]   bpReg;
  logic [7:0]        statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt  <= '0;
      dataHold <= '0;
      welReg   <= 1'b0;
      bpReg    <= '0;
    end else begin
      if (strobe.captureData) dataHold <= rxByte[BP_LSB +: BP_W];
      if (strobe.commitStatus) begin
        bpReg   <= dataHold;
        busyCnt <= BUSY_W'(BUSY_CYCLES);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
        if (busyCnt == BUSY_W'(1)) welReg <= 1'b0;
      end
      if (strobe.setWel) welReg <= 1'b1;
    end
  end

  assign wip = (busyCnt != '0);
  assign wel = welReg;
  assign bp  = bpReg;

  always_comb begin
    statusByte                   = 8'd0;
    statusByte[BP_LSB +: BP_W]   = bpReg;
    statusByte[1]                = welReg;
    statusByte[0]                = wip;
  end

  // transmit shifter
  logic [7:0]        outByte;
  logic [2:0]        outCnt;
  logic [ADDR_W-1:0] readPtr;
  logic              srcStatus;
  logic              sdoReg, oeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outByte   <= 8'd0;
      outCnt    <= 3'd0;
      readPtr   <= '0;
      srcStatus <= 1'b0;
      sdoReg    <= 1'b0;
      oeReg     <= 1'b0;
    end else begin
      if (csS) oeReg <= 1'b0;
      if (strobe.startRead) begin
        readPtr   <= startIdx;
        outByte   <= romByte(startIdx);
        outCnt    <= 3'd0;
        srcStatus <= 1'b0;
      end else if (strobe.startStatus) begin
        outByte   <= statusByte;
        outCnt    <= 3'd0;
        srcStatus <= 1'b1;
      end else if (strobe.shiftOut) begin
        sdoReg <= outByte[3'd7 - outCnt];
        oeReg  <= 1'b1;
        outCnt <= outCnt + 3'd1;
        if (outCnt == 3'd7) begin
          if (srcStatus) begin
            outByte <= statusByte;
          end else begin
            readPtr <= readPtr + 1'b1;
            outByte <= romByte(readPtr + 1'b1);
          end
        end
      end
    end
  end

  assign sdo   = sdoReg;
  assign sdoOe = oeReg;

endmodule

// File: rtl/serialCfgSlave.sv
module serialCfgSlave
  import serialCfgPkg::*;
#(
  parameter int MEM_DEPTH = 64,
  parameter int MEM_SEED = 8'hA5,
  parameter int BP_W = 3,
  parameter int BUSY_CYCLES = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdoOe
);

  ctrlStrobe_t     ctrlStb;
  logic            csHighS, csRiseS, riseS, fallS, byteDoneS;
  logic [7:0]      rxByteS;
  logic            wipS, welS;
  logic [BP_W-1:0] bpS;

  serialCfgCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csHigh(csHighS), .csRiseEv(csRiseS),
    .riseEv(riseS), .fallEv(fallS), .byteDone(byteDoneS), .rxByte(rxByteS),
    .wip(wipS), .wel(welS), .strobe(ctrlStb)
  );

  serialCfgDatapath #(
    .MEM_DEPTH(MEM_DEPTH), .MEM_SEED(MEM_SEED), .BP_W(BP_W),
    .BUSY_CYCLES(BUSY_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .strobe(ctrlStb), .csHigh(csHighS), .csRiseEv(csRiseS), .riseEv(riseS),
    .fallEv(fallS), .byteDone(byteDoneS), .rxByte(rxByteS), .wip(wipS),
    .wel(welS), .bp(bpS), .sdo(sdo), .sdoOe(sdoOe)
  );

endmodule

// File: rtl/serialCfgChecker.sv
module serialCfgChecker
  import serialCfgPkg::*;
#(
  parameter int BP_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            csN,
  input logic            sdo,
  input logic            sdoOe,
  input ctrlStrobe_t     strobe,
  input logic            wip,
  input logic            wel,
  input logic [BP_W-1:0] bp
);

  p_commit_needs_wel_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitStatus |-> wel);

  p_bp_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.commitStatus) |-> $stable(bp));

  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(strobe.commitStatus));

  p_wel_in_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> wel);

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> !(strobe.setWel || strobe.commitStatus || strobe.startRead));

  p_sdo_edges_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.shiftOut) |-> $stable(sdo));

  p_oe_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !sdoOe);

endmodule

bind serialCfgSlave serialCfgChecker #(.BP_W(BP_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdo(sdo), .sdoOe(sdoOe),
  .strobe(ctrlStb), .wip(wipS), .wel(welS), .bp(bpS)
);

// File: tb/serialCfgSlave_bench.sv
module serialCfgSlave_bench;

  localparam int DEPTH = 16;
  localparam int SEED  = 8'h5A;
  localparam int BUSY  = 1000;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdoOe;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit oeSeen;
  bit oeMissing;

  always #10 clk = ~clk;

  serialCfgSlave #(
    .MEM_DEPTH(DEPTH), .MEM_SEED(SEED), .BP_W(3), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)
  ) u_serialCfgSlave (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe)
  );

  function automatic int expByte(int idx);
    return (idx * 29 + SEED) & 255;
  endfunction

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic selLow();
    csN = 1'b0;
    oeSeen = 1'b0;
    oeMissing = 1'b0;
    waitClk(HALF);
  endtask

  task automatic selHigh();
    sclk = 1'b0;
    waitClk(HALF);
    csN = 1'b1;
    waitClk(4 * HALF);
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      sdi = b[7 - i];
      waitClk(HALF);
      if (sdoOe) oeSeen = 1'b1;
      sclk = 1'b1;
      waitClk(HALF);
    end
  endtask

  task automatic recvByte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      sdi = 1'b0;
      waitClk(HALF);
      b[7 - i] = sdo;
      if (sdoOe) oeSeen = 1'b1;
      else oeMissing = 1'b1;
      sclk = 1'b1;
      waitClk(HALF);
    end
  endtask

  task automatic readStatus(int exp, string req, int nBytes);
    logic [7:0] got;
    selLow();
    sendBits(8'h05, 8);
    for (int k = 0; k < nBytes; k++) begin
      recvByte(got);
      check(got == exp[7:0], req, got, exp);
    end
    selHigh();
  endtask

  task automatic tReset();
    logic [7:0] got;
    check(sdoOe == 1'b0, "R1 enable after reset", sdoOe, 0);
    selLow();
    sendBits(8'h05, 8);
    check(!oeSeen, "R11 enable low during opcode", oeSeen, 0);
    recvByte(got);
    check(got == 8'h00, "R1 status after reset", got, 0);
    check(!oeMissing, "R11 enable high in data phase", oeMissing, 0);
    selHigh();
    check(sdoOe == 1'b0, "R11 enable dropped after select", sdoOe, 0);
  endtask

  task automatic tWrsrNoWel();
    selLow();
    sendBits(8'h01, 8);
    sendBits(8'hFF, 8);
    selHigh();
    waitClk(8);
    readStatus(8'h00, "R4 write without latch ignored", 1);
  endtask

  task automatic tWren();
    selLow();
    sendBits(8'h06, 8);
    selHigh();
    readStatus(8'h02, "R2 latch set / R3 repeated status", 2);
  endtask

  task automatic tWrsrAbort();
    selLow();
    sendBits(8'h01, 8);
    sendBits(8'hFF, 7);
    selHigh();
    waitClk(8);
    readStatus(8'h02, "R6 seven data bits discarded", 1);
    selLow();
    sendBits(8'h01, 8);
    sendBits(8'hFF, 8);
    sendBits(8'h80, 1);
    selHigh();
    waitClk(8);
    readStatus(8'h02, "R6 nine data bits discarded", 1);
  endtask

  task automatic tWrsrGoodAndBusy();
    logic [7:0] got;
    selLow();
    sendBits(8'h01, 8);
    sendBits(8'hE8, 8);
    selHigh();
    readStatus(8'h0B, "R5 R7 status during busy", 1);
    selLow();
    sendBits(8'h03, 8);
    sendBits(8'h00, 8);
    sendBits(8'h00, 8);
    sendBits(8'h02, 8);
    recvByte(got);
    check(!oeSeen, "R8 read blocked while busy", oeSeen, 0);
    selHigh();
    readStatus(8'h0B, "R8 status still busy", 1);
    waitClk(BUSY + 200);
    readStatus(8'h08, "R7 busy and latch cleared", 1);
  endtask

  task automatic tRead();
    logic [7:0] got;
    selLow();
    sendBits(8'h03, 8);
    sendBits(8'h00, 8);
    sendBits(8'h00, 8);
    sendBits(8'h05, 8);
    recvByte(got);
    check(got == expByte(5), "R9 first byte", got, expByte(5));
    recvByte(got);
    check(got == expByte(6), "R10 next byte", got, expByte(6));
    selHigh();
  endtask

  task automatic tReadWrap();
    logic [7:0] got;
    selLow();
    sendBits(8'h03, 8);
    sendBits(8'hAB, 8);
    sendBits(8'hCD, 8);
    sendBits(8'h0E, 8);
    recvByte(got);
    check(got == expByte(14), "R9 high address bits dropped", got, expByte(14));
    recvByte(got);
    check(got == expByte(15), "R10 last index", got, expByte(15));
    recvByte(got);
    check(got == expByte(0), "R10 wrap to index 0", got, expByte(0));
    selHigh();
  endtask

  task automatic tUnknownAndAbort();
    logic [7:0] got;
    selLow();
    sendBits(8'h9F, 8);
    recvByte(got);
    check(!oeSeen, "R12 unknown opcode ignored", oeSeen, 0);
    selHigh();
    selLow();
    sendBits(8'h05, 4);
    selHigh();
    readStatus(8'h08, "R12 fresh opcode after abort", 1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      finish();
    end
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    tReset();
    tWrsrNoWel();
    tWren();
    tWrsrAbort();
    tWrsrGoodAndBusy();
    tRead();
    tReadWrap();
    tUnknownAndAbort();
    finish();
  end

endmodule